// File: doc/BRIEF.md
# SPI Slave Command Handler

This block is the slave side of a serial peripheral link. An external master lowers chip select, shifts in an eight-bit opcode, waits a per-operation number of idle clocks, and then either writes or reads a 32-bit status word, or writes or reads a sixteen-word buffer of 32-bit words. The serial pins are sampled in the system clock domain: SCLK and MOSI pass through two-flop synchronisers and edge detection, and chip select also passes through a programmable glitch filter. Local logic fills and inspects the buffer through a host port. It also reads the status word, the done flags, the last accepted opcode, the sequencer state and a count of completed operations.

The sequencer has five states. In `ST_IDLE` (code 0) it waits for a filtered chip select. `ST_CMD` (1) shifts in the opcode. `ST_DUMMY` (2) counts idle clocks. `ST_DATA` (3) moves data words. `ST_DRAIN` (4) waits for chip select to rise. Transitions: IDLE→CMD when chip select goes active. CMD→DUMMY when the eighth opcode bit lands on a valid, enabled opcode, and CMD→DRAIN on any other opcode. DUMMY→DATA on the last idle clock. DATA→DRAIN on the final data bit. Every state returns to IDLE the cycle after the filtered chip select goes inactive.

Top module: `spi_cmd_slave`

## Requirements
- R1: The link uses SPI mode 0: MOSI is sampled on rising SCLK and MISO changes on falling SCLK, both MSB first. The opcode values are 1 = write-status, 2 = write-buffer, 3 = read-buffer and 4 = read-status, compared on all eight bits. Any other opcode leads to `ST_DRAIN` with no effect on any register.
- R2: `status_en` low makes opcodes 1 and 4 ignored, and `buffer_en` low makes opcodes 2 and 3 ignored. An ignored opcode changes no data, no done flag, no count and not `last_cmd`.
- R3: Each operation has its own 8-bit idle-length input. A value of v means v+1 SCLK cycles pass after the opcode before the first data bit.
- R4: Write-status stores the 32 data bits into `status_word` on the 32nd data rising edge.
- R5: Read-status shifts `status_word` out on MISO, MSB first, with the first bit valid before the first data rising edge.
- R6: Write-buffer fills words 0 to 15 in order, one word per 32 bits. Bits after word 15 are ignored.
- R7: Read-buffer shifts out words 0 to 15 in order, MSB first.
- R8: `done_raw` bit 0 is set by write-status, bit 1 by write-buffer, bit 2 by read-buffer, bit 3 by read-status, and bit 4 by any completed operation. The bits are sticky until cleared through `done_clr`. `irq` is the OR of `done_raw & irq_mask`.
- R9: `last_cmd` holds the low three bits of the last accepted opcode. `fsm_state` shows the state code listed above.
- R10: `op_count` adds one for each completed operation and wraps modulo 16.
- R11: Chip select must hold a new level for `cs_filt_mode`+1 synchronised samples before it takes effect. Releasing chip select before the last bit ends the operation with no done flag and no count.
- R12: The host port writes buffer word `host_addr` when `host_we` is high and always shows that word on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| status_en | input | 1 | Enables the status opcodes |
| buffer_en | input | 1 | Enables the buffer opcodes |
| dummy_wsta | input | 8 | Idle length minus one, write-status |
| dummy_wbuf | input | 8 | Idle length minus one, write-buffer |
| dummy_rbuf | input | 8 | Idle length minus one, read-buffer |
| dummy_rsta | input | 8 | Idle length minus one, read-status |
| cs_filt_mode | input | 2 | Chip-select filter depth minus one |
| irq_mask | input | 5 | Enables for the done flags onto `irq` |
| done_clr | input | 5 | Clears the matching done flags |
| done_raw | output | 5 | Sticky done flags |
| irq | output | 1 | Interrupt request |
| last_cmd | output | 3 | Last accepted opcode |
| fsm_state | output | 3 | Sequencer state code |
| op_count | output | 4 | Completed-operation count |
| status_word | output | 32 | Status register |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 4 | Host buffer word index |
| host_wdata | input | 32 | Host buffer write data |
| host_rdata | output | 32 | Buffer word at `host_addr` |

## Verification
The bench sends an opcode whose low three bits are valid but whose upper bits are not. A decoder that checks only three bits would act on it and raise a done flag. It releases chip select mid-word, where a sequencer that ignored the release would later finish the operation and count it. It streams a seventeenth word into the buffer, which a missing end-of-buffer stop would wrap onto word 0. It pulses chip select for three cycles with the deepest filter and then with the shallowest: too weak a filter leaves idle, and too strong a filter stays idle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_DUMMY = 3'd2,
        ST_DATA  = 3'd3,
        ST_DRAIN = 3'd4
    } slv_state_e;

    // operation index doubles as done-flag bit position
    typedef enum logic [1:0] {
        OP_WSTA = 2'd0,
        OP_WBUF = 2'd1,
        OP_RBUF = 2'd2,
        OP_RSTA = 2'd3
    } slv_op_e;

    localparam logic [7:0] CODE_WSTA = 8'd1;
    localparam logic [7:0] CODE_WBUF = 8'd2;
    localparam logic [7:0] CODE_RBUF = 8'd3;
    localparam logic [7:0] CODE_RSTA = 8'd4;

endpackage

// File: rtl/spi_cs_filter.sv
module spi_cs_filter #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_raw,
    input  logic [MODE_W-1:0] mode,
    output logic              cs_act
);
    logic              s1, s2, filt;
    logic [MODE_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            filt <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= cs_n_raw;
            s2 <= s1;
            if (s2 == filt) begin
                cnt <= '0;
            end else if (cnt == mode) begin
                filt <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cs_act = ~filt;
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    logic [2:0] sck_p;
    logic [1:0] dat_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            dat_p <= '0;
        end else begin
            sck_p <= {sck_p[1:0], sclk};
            dat_p <= {dat_p[0], mosi};
        end
    end

    assign sclk_rise = sck_p[1] & ~sck_p[2];
    assign sclk_fall = ~sck_p[1] & sck_p[2];
    assign mosi_s    = dat_p[1];
endmodule

// File: rtl/spi_word_buf.sv
module spi_word_buf #(
    parameter int WORDS = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [AW-1:0]    a_waddr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic [AW-1:0]    a_raddr,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (a_we && a_waddr == AW'(i)) begin
                mem[i] <= a_wdata;
            end else if (b_we && b_addr == AW'(i)) begin
                mem[i] <= b_wdata;
            end
        end
    end

    assign a_rdata = mem[a_raddr];
    assign b_rdata = mem[b_addr];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BUF_WORDS = 16,
    parameter int CMD_W     = 8,
    parameter int DUMMY_W   = 8,
    parameter int CNT_W     = 4,
    parameter int FILT_W    = 2,
    localparam int AW       = $clog2(BUF_WORDS),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int DONE_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    input  logic               status_en,
    input  logic               buffer_en,
    input  logic [DUMMY_W-1:0] dummy_wsta,
    input  logic [DUMMY_W-1:0] dummy_wbuf,
    input  logic [DUMMY_W-1:0] dummy_rbuf,
    input  logic [DUMMY_W-1:0] dummy_rsta,
    input  logic [FILT_W-1:0]  cs_filt_mode,
    input  logic [DONE_W-1:0]  irq_mask,
    input  logic [DONE_W-1:0]  done_clr,
    output logic [DONE_W-1:0]  done_raw,
    output logic               irq,
    output logic [2:0]         last_cmd,
    output logic [2:0]         fsm_state,
    output logic [CNT_W-1:0]   op_count,
    output logic [WORD_W-1:0]  status_word,
    input  logic               host_we,
    input  logic [AW-1:0]      host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata
);
    slv_state_e         state_q, state_d;
    slv_op_e            op_q, cmd_op;
    logic               cs_act, sclk_rise, sclk_fall, mosi_s;
    logic [CMD_W-1:0]   cmd_sh, cmd_full;
    logic [BIT_W-1:0]   bit_q, tx_bit;
    logic [DUMMY_W-1:0] dcnt, dummy_sel;
    logic [AW-1:0]      word_q, tx_word, rd_addr;
    logic [WORD_W-1:0]  rx_sh, tx_sh, word_in, buf_rd, status_q;
    logic [DONE_W-1:0]  done_q, done_set;
    logic [CNT_W-1:0]   opcnt_q;
    logic [2:0]         last_q;
    logic               miso_q, cmd_hit, cmd_last, word_last;
    logic               is_status, is_read, final_word, op_finish, buf_we;

    spi_cs_filter #(.MODE_W(FILT_W)) u_csf (
        .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n), .mode(cs_filt_mode), .cs_act(cs_act)
    );

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
    );

    spi_word_buf #(.WORDS(BUF_WORDS), .WIDTH(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .a_we(buf_we), .a_waddr(word_q), .a_wdata(word_in),
        .a_raddr(rd_addr), .a_rdata(buf_rd),
        .b_we(host_we), .b_addr(host_addr), .b_wdata(host_wdata), .b_rdata(host_rdata)
    );

    // opcode decode
    assign cmd_full = {cmd_sh[CMD_W-2:0], mosi_s};
    always_comb begin
        cmd_hit = 1'b0;
        cmd_op  = OP_WSTA;
        unique case (cmd_full)
            CODE_WSTA: begin cmd_hit = status_en; cmd_op = OP_WSTA; end
            CODE_WBUF: begin cmd_hit = buffer_en; cmd_op = OP_WBUF; end
            CODE_RBUF: begin cmd_hit = buffer_en; cmd_op = OP_RBUF; end
            CODE_RSTA: begin cmd_hit = status_en; cmd_op = OP_RSTA; end
            default:   ;
        endcase
        unique case (cmd_op)
            OP_WSTA: dummy_sel = dummy_wsta;
            OP_WBUF: dummy_sel = dummy_wbuf;
            OP_RBUF: dummy_sel = dummy_rbuf;
            OP_RSTA: dummy_sel = dummy_rsta;
        endcase
    end

    assign cmd_last   = bit_q == BIT_W'(CMD_W - 1);
    assign word_last  = bit_q == BIT_W'(WORD_W - 1);
    assign is_status  = (op_q == OP_WSTA) || (op_q == OP_RSTA);
    assign is_read    = (op_q == OP_RBUF) || (op_q == OP_RSTA);
    assign final_word = is_status || (word_q == AW'(BUF_WORDS - 1));
    assign op_finish  = cs_act && state_q == ST_DATA && sclk_rise && word_last && final_word;
    assign word_in    = {rx_sh[WORD_W-2:0], mosi_s};
    assign buf_we     = cs_act && state_q == ST_DATA && sclk_rise && word_last && op_q == OP_WBUF;
    assign rd_addr    = (state_q == ST_DATA) ? tx_word + 1'b1 : '0;

    always_comb begin
        done_set = '0;
        if (op_finish) begin
            done_set[op_q]       = 1'b1;
            done_set[DONE_W-1]   = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD:   if (sclk_rise && cmd_last) state_d = cmd_hit ? ST_DUMMY : ST_DRAIN;
                ST_DUMMY: if (sclk_rise && dcnt == '0) state_d = ST_DATA;
                ST_DATA:  if (op_finish) state_d = ST_DRAIN;
                ST_DRAIN: state_d = ST_DRAIN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_WSTA;   cmd_sh <= '0;  bit_q <= '0;  tx_bit <= '0;
            dcnt <= '0;        word_q <= '0;  tx_word <= '0;
            rx_sh <= '0;       tx_sh <= '0;   status_q <= '0;
            done_q <= '0;      opcnt_q <= '0; last_q <= '0; miso_q <= 1'b0;
        end else begin
            done_q <= (done_q & ~done_clr) | done_set;
            if (op_finish) opcnt_q <= opcnt_q + 1'b1;
            if (!cs_act) begin
                miso_q <= 1'b0;
                bit_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        bit_q  <= '0;
                        miso_q <= 1'b0;
                    end
                    ST_CMD: if (sclk_rise) begin
                        cmd_sh <= cmd_full;
                        bit_q  <= bit_q + 1'b1;
                        if (cmd_last) begin
                            bit_q <= '0;
                            if (cmd_hit) begin
                                op_q   <= cmd_op;
                                last_q <= cmd_full[2:0];
                                dcnt   <= dummy_sel;
                            end
                        end
                    end
                    ST_DUMMY: if (sclk_rise) begin
                        if (dcnt == '0) begin
                            word_q  <= '0;
                            tx_word <= '0;
                            tx_bit  <= '0;
                            tx_sh   <= (op_q == OP_RSTA) ? status_q : buf_rd;
                        end else begin
                            dcnt <= dcnt - 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (sclk_rise) begin
                            rx_sh <= word_in;
                            bit_q <= bit_q + 1'b1;
                            if (word_last) begin
                                bit_q <= '0;
                                if (op_q == OP_WSTA) status_q <= word_in;
                                if (!final_word) word_q <= word_q + 1'b1;
                            end
                        end
                        if (sclk_fall && is_read) begin
                            miso_q <= tx_sh[WORD_W-1];
                            tx_sh  <= tx_sh << 1;
                            tx_bit <= tx_bit + 1'b1;
                            if (tx_bit == BIT_W'(WORD_W - 1)) begin
                                tx_sh   <= buf_rd;
                                tx_word <= tx_word + 1'b1;
                            end
                        end
                    end
                    ST_DRAIN: ;
                    default:  ;
                endcase
            end
        end
    end

    assign miso        = miso_q;
    assign done_raw    = done_q;
    assign irq         = |(done_q & irq_mask);
    assign last_cmd    = last_q;
    assign fsm_state   = state_q;
    assign op_count    = opcnt_q;
    assign status_word = status_q;
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
    parameter int CNT_W  = 4,
    parameter int DONE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic [2:0]        fsm_state,
    input logic [2:0]        last_cmd,
    input logic [CNT_W-1:0]  op_count,
    input logic [DONE_W-1:0] done_raw
);
    // R9: only the five defined state codes appear
    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state <= 3'd4);

    // R9: last_cmd only moves when the previous cycle was in the opcode state
    a_r9_last_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cmd != $past(last_cmd)) |-> ($past(fsm_state) == 3'd1));

    // R11: a released chip select returns the sequencer to idle
    a_r11_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (fsm_state == 3'd0));

    // R10: the count never skips
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (op_count == $past(op_count) || op_count == $past(op_count) + 1'b1));

    // R8: a newly set per-operation flag comes with the any-operation flag
    a_r8_any_with_op: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_raw[DONE_W-2:0] & ~$past(done_raw[DONE_W-2:0]))) |-> done_raw[DONE_W-1]);

    // R8 / R10: a new flag is accompanied by a count step
    a_r10_count_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_raw[DONE_W-2:0] & ~$past(done_raw[DONE_W-2:0]))) |-> (op_count != $past(op_count)));
endmodule

bind spi_cmd_slave spi_cmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fsm_state(fsm_state),
    .last_cmd(last_cmd), .op_count(op_count), .done_raw(done_raw)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
    localparam int HP = 8;

    logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, irq, status_en = 1'b1, buffer_en = 1'b1, host_we = 1'b0;
    logic [7:0]  dummy_wsta = 8'd0, dummy_wbuf = 8'd1, dummy_rbuf = 8'd3, dummy_rsta = 8'd2;
    logic [1:0]  cs_filt_mode = 2'd1;
    logic [4:0]  irq_mask = 5'd0, done_clr = 5'd0, done_raw;
    logic [2:0]  last_cmd, fsm_state;
    logic [3:0]  op_count, host_addr = 4'd0;
    logic [31:0] status_word, host_wdata = 32'd0, host_rdata;

    int total = 0, bad = 0, exp_ops = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .status_en(status_en), .buffer_en(buffer_en),
        .dummy_wsta(dummy_wsta), .dummy_wbuf(dummy_wbuf), .dummy_rbuf(dummy_rbuf),
        .dummy_rsta(dummy_rsta), .cs_filt_mode(cs_filt_mode), .irq_mask(irq_mask),
        .done_clr(done_clr), .done_raw(done_raw), .irq(irq), .last_cmd(last_cmd),
        .fsm_state(fsm_state), .op_count(op_count), .status_word(status_word),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // status vectors: {data, read-status idle setting}
    localparam logic [39:0] VEC [6] = '{
        {32'hDEADBEEF, 8'd2}, {32'h00000001, 8'd0}, {32'h80000000, 8'd5},
        {32'h5A5A0F0F, 8'd1}, {32'hFFFFFFFF, 8'd3}, {32'h13572468, 8'd7}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [31:0] v, input int n, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = v[i];
            wait_cyc(HP);
            rx = {rx[30:0], miso};
            sclk = 1'b1;
            wait_cyc(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_cyc(12);
    endtask

    task automatic cs_end();
        wait_cyc(4);
        cs_n = 1'b1;
        wait_cyc(12);
    endtask

    task automatic clr_done();
        done_clr = 5'h1f;
        wait_cyc(1);
        done_clr = 5'h00;
        wait_cyc(1);
    endtask

    task automatic status_op(input logic [7:0] code, input int idle, input logic [31:0] wd,
                             output logic [31:0] rx);
        logic [31:0] junk;
        cs_begin();
        spi_bits({24'd0, code}, 8, junk);
        spi_bits(32'd0, idle, junk);
        spi_bits(wd, 32, rx);
        cs_end();
    endtask

    function automatic logic [31:0] fword(input int i);
        return {8'hC3, 8'(i), 16'(i * 37 + 5)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx, junk, stat_keep;
        bit seen;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // reset state
        chk("R9 reset fsm_state", 32'(fsm_state), 32'd0);
        chk("R9 reset last_cmd", 32'(last_cmd), 32'd0);
        chk("R8 reset done_raw", 32'(done_raw), 32'd0);
        chk("R10 reset op_count", 32'(op_count), 32'd0);
        chk("R4 reset status", status_word, 32'd0);
        chk("R1 reset miso", 32'(miso), 32'd0);

        // vector table: write then read status with varying idle lengths (R3 R4 R5)
        foreach (VEC[k]) begin
            clr_done();
            status_op(8'd1, 1, VEC[k][39:8], rx);
            exp_ops++;
            chk("R4 status written", status_word, VEC[k][39:8]);
            chk("R8 wsta flags", 32'(done_raw), 32'h11);
            chk("R9 last_cmd wsta", 32'(last_cmd), 32'd1);
            dummy_rsta = VEC[k][7:0];
            clr_done();
            status_op(8'd4, int'(VEC[k][7:0]) + 1, 32'd0, rx);
            exp_ops++;
            chk("R5 R3 status readback", rx, VEC[k][39:8]);
            chk("R8 rsta flags", 32'(done_raw), 32'h18);
            chk("R9 last_cmd rsta", 32'(last_cmd), 32'd4);
        end
        stat_keep = status_word;

        // write-buffer, 17 words, last one must be dropped (R6 R8 R12)
        clr_done();
        irq_mask = 5'b00010;
        cs_begin();
        spi_bits(32'd2, 8, junk);
        spi_bits(32'd0, 2, junk);
        for (int w = 0; w < 16; w++) spi_bits(fword(w), 32, junk);
        chk("R9 drain after final word", 32'(fsm_state), 32'd4);
        spi_bits(32'hFFFFFFFF, 32, junk);
        cs_end();
        exp_ops++;
        chk("R8 wbuf flags", 32'(done_raw), 32'h12);
        chk("R8 irq masked on", 32'(irq), 32'd1);
        for (int w = 0; w < 16; w += 5) begin
            host_addr = 4'(w);
            wait_cyc(1);
            chk("R6 R12 buffer word", host_rdata, fword(w));
        end
        host_addr = 4'd15;
        wait_cyc(1);
        chk("R6 word 15", host_rdata, fword(15));
        clr_done();
        chk("R8 irq after clear", 32'(irq), 32'd0);
        irq_mask = 5'b00001;

        // host preload then read-buffer (R7 R12)
        for (int w = 0; w < 16; w++) begin
            host_addr = 4'(w);
            host_wdata = ~fword(w);
            host_we = 1'b1;
            wait_cyc(1);
        end
        host_we = 1'b0;
        cs_begin();
        spi_bits(32'd3, 8, junk);
        spi_bits(32'd0, 4, junk);
        for (int w = 0; w < 16; w++) begin
            spi_bits(32'd0, 32, rx);
            chk("R7 read-buffer word", rx, ~fword(w));
        end
        cs_end();
        exp_ops++;
        chk("R8 rbuf flags", 32'(done_raw), 32'h14);
        chk("R8 irq masked off", 32'(irq), 32'd0);
        clr_done();

        // disabled groups (R2)
        status_en = 1'b0;
        status_op(8'd1, 1, 32'h12345678, rx);
        chk("R2 status write ignored", status_word, stat_keep);
        chk("R2 no flags", 32'(done_raw), 32'd0);
        chk("R2 last_cmd kept", 32'(last_cmd), 32'd3);
        status_en = 1'b1;
        buffer_en = 1'b0;
        cs_begin();
        spi_bits(32'd2, 8, junk);
        spi_bits(32'd0, 2, junk);
        spi_bits(32'hAAAA5555, 32, junk);
        cs_end();
        host_addr = 4'd0;
        wait_cyc(1);
        chk("R2 buffer write ignored", host_rdata, ~fword(0));
        chk("R2 count unchanged", 32'(op_count), 32'(exp_ops % 16));
        buffer_en = 1'b1;

        // undefined opcodes (R1)
        status_op(8'h05, 1, 32'h0BADF00D, rx);
        status_op(8'h81, 1, 32'h0BADF00D, rx);
        chk("R1 bad opcode no write", status_word, stat_keep);
        chk("R1 bad opcode no flags", 32'(done_raw), 32'd0);
        chk("R1 bad opcode last_cmd", 32'(last_cmd), 32'd3);

        // early release (R11)
        cs_begin();
        spi_bits(32'd1, 8, junk);
        spi_bits(32'd0, 1, junk);
        spi_bits(32'hFFF, 12, junk);
        cs_end();
        chk("R11 abort no write", status_word, stat_keep);
        chk("R11 abort no flags", 32'(done_raw), 32'd0);
        chk("R11 abort idle", 32'(fsm_state), 32'd0);
        chk("R11 abort no count", 32'(op_count), 32'(exp_ops % 16));

        // glitch filter depth (R11)
        cs_filt_mode = 2'd3;
        wait_cyc(2);
        seen = 1'b0;
        cs_n = 1'b0;
        wait_cyc(3);
        cs_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            if (fsm_state != 3'd0) seen = 1'b1;
            wait_cyc(1);
        end
        chk("R11 deep filter rejects 3-cycle pulse", 32'(seen), 32'd0);
        cs_filt_mode = 2'd0;
        wait_cyc(2);
        seen = 1'b0;
        cs_n = 1'b0;
        wait_cyc(3);
        cs_n = 1'b1;
        for (int c = 0; c < 12; c++) begin
            if (fsm_state != 3'd0) seen = 1'b1;
            wait_cyc(1);
        end
        chk("R11 shallow filter accepts 3-cycle pulse", 32'(seen), 32'd1);

        // state walk under deep filter (R9 R3)
        cs_filt_mode = 2'd3;
        dummy_rsta = 8'd2;
        cs_begin();
        chk("R9 state cmd", 32'(fsm_state), 32'd1);
        spi_bits(32'd4, 8, junk);
        spi_bits(32'd0, 1, junk);
        chk("R9 R3 state dummy", 32'(fsm_state), 32'd2);
        spi_bits(32'd0, 2, junk);
        chk("R9 R3 state data", 32'(fsm_state), 32'd3);
        spi_bits(32'd0, 32, rx);
        chk("R5 readback deep filter", rx, stat_keep);
        cs_end();
        exp_ops++;

        // push count past wrap (R10)
        for (int k = 0; k < 3; k++) begin
            status_op(8'd1, 1, 32'(k + 100), rx);
            exp_ops++;
        end
        chk("R4 last write", status_word, 32'd102);
        chk("R10 count wraps", 32'(op_count), 32'(exp_ops % 16));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule